// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates a bank of stoppable PCI-rate clocks, a pair of free-running PCI-rate clocks and a differential CPU-rate clock pair. The source clock waveforms arrive as level signals sampled by the fabric clock `clk`, for example from an upstream divider. Every output is a registered copy of its source, delayed by one `clk` cycle. The copy is passed or suppressed only in whole high phases, so an output never carries a shortened pulse.

Two active-low stop requests park the clocks. The PCI request parks the stoppable outputs low. The CPU request parks the pair with the true output low and the complement output high, after the request has been seen on two rising edges of the CPU source. A mode strap is captured while reset is held. Stop requests act only when the captured mode is 1, which is mobile mode. A per-output enable bit can also force an output to its parked level in either mode. The free-running outputs obey their enable bits only.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While the captured mode is 1 and `pci_stop_n` is 0, every stoppable PCI output stays at 0. A high phase that is already in progress completes at full length before the output parks.
- R2: A PCI stop or enable change is recognised for a source high phase only if it is present in the `clk` cycle before that phase's rising edge. A request that first appears in the cycle where `pci_src` rises takes effect from the next high phase.
- R3: The free-running outputs copy `pci_src` whenever their enable bit is 1, regardless of `pci_stop_n`.
- R4: While the captured mode is 1, a CPU stop request must be sampled on two rising edges of `cpu_src`. Only after that is the pair parked from its next low phase on. Releasing the request follows the same latency, so with a source period of 4 `clk` cycles the effect appears one 8-cycle PCI period later.
- R5: `cpu_c_o` is always the inverse of `cpu_t_o`. A parked pair shows `cpu_t_o` = 0 and `cpu_c_o` = 1.
- R6: The mode strap is captured only while `rst` is 1. With a captured mode of 0, both stop requests are ignored. A later change on the strap input has no effect until the next reset.
- R7: An enable bit of 0 parks its output (low, or the CPU pair as in R5) from the next source low phase. An enable bit of 1 lets the output run. Bit i of `pci_en` controls `pci_clk_o[i]`, and bit j of `free_en` controls `pci_free_o[j]`.
- R8: After a stop is released, an output restarts with a complete high phase and never with a partial one.
- R9: While reset is held and right after it, all outputs are 0 except `cpu_c_o`, which is 1.
- R10: Every output changes only on `clk` and follows its source with exactly one `clk` cycle of delay. An output rises only when its source was high in the previous cycle, and falls only when its source was low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples all sources |
| rst | input | 1 | Synchronous active-high reset; mode strap captured while high |
| mode_strap | input | 1 | Mode strap level, 1 = mobile (stop requests honoured) |
| pci_src | input | 1 | PCI-rate source clock waveform |
| cpu_src | input | 1 | CPU-rate source clock waveform |
| pci_stop_n | input | 1 | Active-low stop request for the stoppable PCI outputs |
| cpu_stop_n | input | 1 | Active-low stop request for the CPU pair |
| pci_en | input | N_STOP | Enable bits of the stoppable PCI outputs |
| free_en | input | N_FREE | Enable bits of the free-running PCI outputs |
| cpu_en | input | 1 | Enable bit of the CPU pair |
| pci_clk_o | output | N_STOP | Gated stoppable PCI clocks |
| pci_free_o | output | N_FREE | Free-running PCI clocks |
| cpu_t_o | output | 1 | CPU pair, true output |
| cpu_c_o | output | 1 | CPU pair, complement output |

## Verification
The hardest case is the CPU request's two-edge latency acting together with the one-period release latency. The pair keeps running for a whole period after the request and stays parked for a whole period after release. The stimulus therefore holds the CPU request across several consecutive periods and checks both pulses of each period.

The PCI setup boundary is reached by dropping the request in the last low cycle of one period and then exactly on the rising cycle of another. Mode 0 is reached by a second reset with the strap low. The strap is also toggled outside reset, and the stops must still act afterwards.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  // Active-high stop requests after mode qualification.
  typedef struct packed {
    logic pci;
    logic cpu;
  } stop_req_t;

  localparam int unsigned CPU_SYNC_STAGES = 2;
endpackage

// File: rtl/clkstop_edge_sync.sv
// Shifts a request through STAGES registers, advancing only on rising
// edges of the sampled source clock.
module clkstop_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic req_i,
  output logic req_o
);
  logic              src_q;
  logic [STAGES-1:0] sh_q;
  logic              rise;

  assign rise = src_i & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      src_q <= src_i;
      if (rise) sh_q <= {sh_q[STAGES-2:0], req_i};
    end
  end

  assign req_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
// Whole-pulse gate: the run flag is refreshed only while the source is
// low, so a high phase is either passed completely or not at all.
module clkstop_gate #(
  parameter bit INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic allow_i,
  output logic out_o
);
  logic run_q;
  logic pass;

  assign pass = src_i & run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else if (!src_i) run_q <= allow_i;
  end

  generate
    if (INVERT) begin : g_inv
      always_ff @(posedge clk) begin
        if (rst) out_o <= 1'b1;
        else     out_o <= ~pass;
      end
    end else begin : g_true
      always_ff @(posedge clk) begin
        if (rst) out_o <= 1'b0;
        else     out_o <= pass;
      end
    end
  endgenerate
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int unsigned N_STOP = 6,
  parameter int unsigned N_FREE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_strap,
  input  logic              pci_src,
  input  logic              cpu_src,
  input  logic              pci_stop_n,
  input  logic              cpu_stop_n,
  input  logic [N_STOP-1:0] pci_en,
  input  logic [N_FREE-1:0] free_en,
  input  logic              cpu_en,
  output logic [N_STOP-1:0] pci_clk_o,
  output logic [N_FREE-1:0] pci_free_o,
  output logic              cpu_t_o,
  output logic              cpu_c_o
);
  logic      mode_q;
  stop_req_t req;
  logic      cpu_req_sync;
  logic      cpu_allow;

  // Strap capture happens only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_strap;
  end

  assign req.pci = mode_q & ~pci_stop_n;
  assign req.cpu = mode_q & ~cpu_stop_n;

  clkstop_edge_sync #(.STAGES(CPU_SYNC_STAGES)) cpu_sync_i (
    .clk   (clk),
    .rst   (rst),
    .src_i (cpu_src),
    .req_i (req.cpu),
    .req_o (cpu_req_sync)
  );

  assign cpu_allow = cpu_en & ~cpu_req_sync;

  for (genvar i = 0; i < N_STOP; i++) begin : g_stop
    clkstop_gate #(.INVERT(1'b0)) gate_i (
      .clk     (clk),
      .rst     (rst),
      .src_i   (pci_src),
      .allow_i (pci_en[i] & ~req.pci),
      .out_o   (pci_clk_o[i])
    );
  end

  for (genvar j = 0; j < N_FREE; j++) begin : g_free
    clkstop_gate #(.INVERT(1'b0)) gate_i (
      .clk     (clk),
      .rst     (rst),
      .src_i   (pci_src),
      .allow_i (free_en[j]),
      .out_o   (pci_free_o[j])
    );
  end

  clkstop_gate #(.INVERT(1'b0)) cpu_t_i (
    .clk     (clk),
    .rst     (rst),
    .src_i   (cpu_src),
    .allow_i (cpu_allow),
    .out_o   (cpu_t_o)
  );

  clkstop_gate #(.INVERT(1'b1)) cpu_c_i (
    .clk     (clk),
    .rst     (rst),
    .src_i   (cpu_src),
    .allow_i (cpu_allow),
    .out_o   (cpu_c_o)
  );
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int unsigned N_STOP = 6,
  parameter int unsigned N_FREE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pci_src,
  input logic              cpu_src,
  input logic [N_STOP-1:0] pci_clk_o,
  input logic [N_FREE-1:0] pci_free_o,
  input logic              cpu_t_o,
  input logic              cpu_c_o
);
  // R5: the complement output is always the inverse of the true output.
  a_r5_pair_inverse: assert property (@(posedge clk) disable iff (rst)
    cpu_c_o == ~cpu_t_o);

  // R10: the CPU true output is high only after a high source cycle.
  a_r10_cpu_high_src: assert property (@(posedge clk) disable iff (rst)
    cpu_t_o |-> $past(cpu_src));

  // R10: the CPU true output falls only after the source has gone low.
  a_r10_cpu_fall_src: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_t_o) |-> !$past(cpu_src));

  for (genvar i = 0; i < N_STOP; i++) begin : g_stop
    // R1: no truncated pulse; a fall follows only a low source cycle.
    a_r1_no_runt: assert property (@(posedge clk) disable iff (rst)
      $fell(pci_clk_o[i]) |-> !$past(pci_src));
    // R10: a stoppable output is high only after a high source cycle.
    a_r10_stop_high_src: assert property (@(posedge clk) disable iff (rst)
      pci_clk_o[i] |-> $past(pci_src));
  end

  for (genvar j = 0; j < N_FREE; j++) begin : g_free
    // R3: free-running outputs track the source phase.
    a_r3_free_high_src: assert property (@(posedge clk) disable iff (rst)
      pci_free_o[j] |-> $past(pci_src));
  end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_STOP(N_STOP), .N_FREE(N_FREE)) chk_i (.*);

// File: tb/clk_stop_ctrl_tb_top.sv
module clk_stop_ctrl_tb_top;
  localparam int NS = 6;
  localparam int NF = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_strap = 1'b1;
  logic          pci_src = 1'b0;
  logic          cpu_src = 1'b0;
  logic          pci_stop_n = 1'b1;
  logic          cpu_stop_n = 1'b1;
  logic [NS-1:0] pci_en = '1;
  logic [NF-1:0] free_en = '1;
  logic          cpu_en = 1'b1;
  logic [NS-1:0] pci_clk_o;
  logic [NF-1:0] pci_free_o;
  logic          cpu_t_o;
  logic          cpu_c_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_stop_ctrl #(.N_STOP(NS), .N_FREE(NF)) dut_i (.*);

  typedef struct {
    int            pt;
    string         tag;
    logic [NS-1:0] pci;
    logic [NF-1:0] fr;
    logic          cpu;
  } exp_t;

  exp_t q[$];
  event mon_ev;
  logic exp_mode = 1'b1;
  logic prev_cstop = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per sample point and compares outputs.
  initial forever begin
    exp_t e;
    @(mon_ev);
    e = q.pop_front();
    case (e.pt)
      0: begin
        chk({e.tag, " low phase stoppable"}, 16'(pci_clk_o), 16'(0));
        chk({e.tag, " low phase free"}, 16'(pci_free_o), 16'(0));
        chk({e.tag, " R5 low phase pair"}, {14'(0), cpu_t_o, cpu_c_o}, 16'b01);
      end
      1: chk({e.tag, " R5 cpu pulse a"}, {14'(0), cpu_t_o, cpu_c_o}, {14'(0), e.cpu, ~e.cpu});
      default: begin
        chk({e.tag, " stoppable high"}, 16'(pci_clk_o), 16'(e.pci));
        chk({e.tag, " R3 free high"}, 16'(pci_free_o), 16'(e.fr));
        chk({e.tag, " R5 cpu pulse b"}, {14'(0), cpu_t_o, cpu_c_o}, {14'(0), e.cpu, ~e.cpu});
      end
    endcase
  end

  // Driver: one 8-cycle PCI period (4 low, 4 high); CPU source 2 low/2 high.
  task automatic run_period(input string tag, input logic [NS-1:0] pen,
                            input logic [NF-1:0] fen, input logic cen,
                            input int pstop_from, input logic cstop);
    exp_t e;
    e.tag = tag;
    e.pci = (exp_mode && pstop_from <= 3) ? '0 : pen;
    e.fr  = fen;
    e.cpu = cen & ~(exp_mode & prev_cstop);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 2 || k == 3 || k == 7) begin
        e.pt = (k == 2) ? 0 : (k == 3) ? 1 : 2;
        q.push_back(e);
        ->mon_ev;
        #1;
      end
      pci_en     = pen;
      free_en    = fen;
      cpu_en     = cen;
      cpu_stop_n = ~cstop;
      pci_stop_n = (k >= pstop_from) ? 1'b0 : 1'b1;
      pci_src    = (k >= 4);
      cpu_src    = (k % 4) >= 2;
    end
    prev_cstop = cstop;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mode_strap = m; pci_src = 1'b0; cpu_src = 1'b0;
    pci_stop_n = 1'b1; cpu_stop_n = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    exp_mode = m;
    prev_cstop = 1'b0;
    @(negedge clk);
    chk("R9 reset state", {6'(0), pci_clk_o, pci_free_o, cpu_t_o, cpu_c_o}, 16'b1);
  endtask

  initial begin
    do_reset(1'b1);
    run_period("R10 all running", '1, '1, 1'b1, 99, 1'b0);
    run_period("R1 pci stop", '1, '1, 1'b1, 0, 1'b0);
    run_period("R8 pci release", '1, '1, 1'b1, 99, 1'b0);
    run_period("R2 stop in last low cycle", '1, '1, 1'b1, 3, 1'b0);
    run_period("R2 stop on rising cycle", '1, '1, 1'b1, 4, 1'b0);
    run_period("R8 restart after late stop", '1, '1, 1'b1, 99, 1'b0);
    run_period("R4 cpu stop first period", '1, '1, 1'b1, 99, 1'b1);
    run_period("R4 cpu stop parked", '1, '1, 1'b1, 99, 1'b1);
    run_period("R4 cpu release latency", '1, '1, 1'b1, 99, 1'b0);
    run_period("R8 cpu restart", '1, '1, 1'b1, 99, 1'b0);
    run_period("R7 enable pattern", 6'b101010, 2'b01, 1'b0, 99, 1'b0);
    run_period("R7 enable pattern b", 6'b010101, 2'b10, 1'b1, 99, 1'b0);
    mode_strap = 1'b0;
    run_period("R6 strap change ignored", '1, '1, 1'b1, 0, 1'b1);
    run_period("R6 strap change cpu", '1, '1, 1'b1, 0, 1'b1);
    run_period("R3 release both", '1, '1, 1'b1, 99, 1'b0);
    do_reset(1'b0);
    run_period("R6 mode0 stops ignored", '1, '1, 1'b1, 0, 1'b1);
    run_period("R6 mode0 stops held", '1, '1, 1'b1, 0, 1'b1);
    run_period("R7 mode0 enable off", 6'b000011, 2'b00, 1'b0, 0, 1'b1);
    run_period("R6 mode0 release", '1, '1, 1'b1, 99, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule